// File: doc/BRIEF.md
# Supervisory Reset and Chip-Enable Controller

This block is a synchronous supervisor. It drives the active-low system reset, gates an active-low chip-enable, and reports watchdog status. Two inputs cause a reset. The first is a manual-reset request (active low), which may come straight from a switch or from a wired-OR of other reset sources. The second is a digital low-supply flag produced by an external comparator. Both inputs are brought into the clock domain through two-flop synchronizers. Reset stays asserted while either cause is present. After the last cause goes away, reset is held for a further programmable number of cycles. The block also asserts reset from its own power-on and runs one full timeout before the first release.

A manual-reset request that stays low for at least a programmable minimum width counts as qualified. While the request is qualified, the watchdog state is cleared and both watchdog outputs are forced inactive (high). The watchdog timeout generator is external. It sends a one-cycle trip strobe, and software or logic acknowledges it with a clear strobe. The block turns these into a latched fault output and a fixed-width fault pulse output. The chip-enable output passes the chip-enable input through while the system runs, and is blocked (held high) whenever reset is asserted.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rstN` is low, `sysRstN` is 0, `chipEnOutN` is 1 and both watchdog outputs are 1. With both causes inactive, `sysRstN` rises after exactly TIMEOUT_CYCLES+1 rising clock edges counted from the first edge that sees `rstN` high.
- R2: After `manRstN` falls, `sysRstN` is low by the third rising edge and not before it. It stays low for as long as `manRstN` stays low.
- R3: After `manRstN` returns high, `sysRstN` rises on exactly the (TIMEOUT_CYCLES+3)-th rising edge. Once `sysRstN` is high, it never falls unless a cause was present three edges earlier.
- R4: A high `lowSupply` asserts and releases `sysRstN` with the same latencies as the manual request in R2 and R3.
- R5: If any cause reappears, even for one cycle, while the timeout is running, the timeout restarts from zero. Release then comes TIMEOUT_CYCLES+3 edges after that cause clears.
- R6: A manual-reset low of at least QUAL_CYCLES sampled edges qualifies and clears the latched watchdog fault and the pulse counter. A low of QUAL_CYCLES-1 edges leaves the fault latched.
- R7: While the request is qualified, `wdFaultN` and `wdStrobeN` read 1, `sysRstN` reads 0, and a trip strobe is ignored.
- R8: `chipEnOutN` equals `chipEnInN` while `sysRstN` is 1, and reads 1 whenever `sysRstN` is 0.
- R9: A trip (`wdTrip`=1) sets `wdFaultN` to 0 after the next edge, and it stays 0 until a clear (`wdClear`=1). A clear takes priority over a trip in the same cycle, and that trip is dropped.
- R10: A trip drives `wdStrobeN` low for exactly PULSE_CYCLES cycles after the edge that samples it. A new trip during the pulse reloads the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, asynchronous, active low |
| manRstN | input | 1 | Manual-reset request, asynchronous, active low |
| lowSupply | input | 1 | Low-supply flag from an external comparator, asynchronous, active high |
| chipEnInN | input | 1 | Chip-enable request, active low |
| wdTrip | input | 1 | One-cycle watchdog expiry strobe |
| wdClear | input | 1 | Watchdog fault acknowledge strobe |
| sysRstN | output | 1 | System reset, active low |
| chipEnOutN | output | 1 | Gated chip-enable, active low |
| wdFaultN | output | 1 | Latched watchdog fault, active low |
| wdStrobeN | output | 1 | Watchdog fault pulse, active low |

## Verification
Each cause input passes through two synchronizer flops and then the state register. Reset is therefore due on the third edge after a cause appears, and release is due on edge TIMEOUT_CYCLES+3 after it clears. The bench samples one edge early and exactly on time, so an off-by-one error in either direction is caught. Watchdog outputs are due one edge after a trip or clear. The chip-enable output is combinational and is read in the same cycle as its input. Qualification is decided QUAL_CYCLES+2 edges after the request falls, so the bench probes pulses of QUAL_CYCLES-1 and exactly QUAL_CYCLES edges.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_TIMING = 2'd1,
    ST_RUN    = 2'd2
  } rstState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic tmrInc;
    logic wdSet;
    logic wdClr;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic manLow;
    logic supLow;
    logic tmrDone;
    logic qualified;
  } dpStat_t;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 70_000_000,
  parameter int QUAL_CYCLES    = 3750,
  parameter int PULSE_CYCLES   = 250,
  parameter int SYNC_STAGES    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    manRstN,
  input  logic    lowSupply,
  input  dpCtrl_t ctrl,
  output dpStat_t stat,
  output logic    faultLatched,
  output logic    pulseActive
);

  localparam int TMR_W   = $clog2(TIMEOUT_CYCLES + 1);
  localparam int QUAL_W  = $clog2(QUAL_CYCLES + 1);
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] manPipe;
  logic [SYNC_STAGES-1:0] supPipe;
  logic [TMR_W-1:0]       tmrCnt;
  logic [QUAL_W-1:0]      qualCnt;
  logic [PULSE_W-1:0]     pulseCnt;
  logic                   manSync;
  logic                   supSync;

  // synchronizer chains; inactive levels on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      manPipe <= '1;
      supPipe <= '0;
    end else begin
      manPipe <= {manPipe[SYNC_STAGES-2:0], manRstN};
      supPipe <= {supPipe[SYNC_STAGES-2:0], lowSupply};
    end
  end

  assign manSync = manPipe[SYNC_STAGES-1];
  assign supSync = supPipe[SYNC_STAGES-1];

  // reset timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (ctrl.tmrClr) begin
      tmrCnt <= '0;
    end else if (ctrl.tmrInc) begin
      tmrCnt <= tmrCnt + TMR_W'(1);
    end
  end

  // minimum-width qualifier, saturates at the qualifying count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
    end else if (manSync) begin
      qualCnt <= '0;
    end else if (qualCnt != QUAL_W'(QUAL_CYCLES)) begin
      qualCnt <= qualCnt + QUAL_W'(1);
    end
  end

  // watchdog fault latch and pulse stretcher
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultLatched <= 1'b0;
      pulseCnt     <= '0;
    end else if (ctrl.wdClr) begin
      faultLatched <= 1'b0;
      pulseCnt     <= '0;
    end else if (ctrl.wdSet) begin
      faultLatched <= 1'b1;
      pulseCnt     <= PULSE_W'(PULSE_CYCLES);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PULSE_W'(1);
    end
  end

  assign pulseActive    = (pulseCnt != '0);
  assign stat.manLow    = ~manSync;
  assign stat.supLow    = supSync;
  assign stat.tmrDone   = (tmrCnt == TMR_W'(TIMEOUT_CYCLES - 1));
  assign stat.qualified = (qualCnt == QUAL_W'(QUAL_CYCLES));

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    faultLatched,
  input  logic    pulseActive,
  input  logic    chipEnInN,
  input  logic    wdTrip,
  input  logic    wdClear,
  output dpCtrl_t ctrl,
  output logic    sysRstN,
  output logic    chipEnOutN,
  output logic    wdFaultN,
  output logic    wdStrobeN
);

  rstState_t state;
  rstState_t stateNext;
  logic      cause;

  assign cause = stat.manLow | stat.supLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HOLD;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext   = state;
    ctrl.tmrClr = 1'b1;
    ctrl.tmrInc = 1'b0;
    unique case (state)
      ST_HOLD: begin
        if (!cause) stateNext = ST_TIMING;
      end
      ST_TIMING: begin
        if (cause) begin
          stateNext = ST_HOLD;
        end else if (stat.tmrDone) begin
          stateNext = ST_RUN;
        end else begin
          ctrl.tmrClr = 1'b0;
          ctrl.tmrInc = 1'b1;
        end
      end
      ST_RUN: begin
        if (cause) stateNext = ST_HOLD;
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  // qualification beats clear, clear beats trip
  assign ctrl.wdClr = stat.qualified | wdClear;
  assign ctrl.wdSet = wdTrip & ~ctrl.wdClr;

  assign sysRstN    = (state == ST_RUN);
  assign chipEnOutN = chipEnInN | ~sysRstN | stat.qualified;
  assign wdFaultN   = ~(faultLatched & ~stat.qualified);
  assign wdStrobeN  = ~(pulseActive & ~stat.qualified);

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 70_000_000,
  parameter int QUAL_CYCLES    = 3750,
  parameter int PULSE_CYCLES   = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic manRstN,
  input  logic lowSupply,
  input  logic chipEnInN,
  input  logic wdTrip,
  input  logic wdClear,
  output logic sysRstN,
  output logic chipEnOutN,
  output logic wdFaultN,
  output logic wdStrobeN
);

  dpCtrl_t ctrl;
  dpStat_t stat;
  logic    faultLatched;
  logic    pulseActive;
  logic    manQualified;

  supv_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .QUAL_CYCLES   (QUAL_CYCLES),
    .PULSE_CYCLES  (PULSE_CYCLES),
    .SYNC_STAGES   (2)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .manRstN     (manRstN),
    .lowSupply   (lowSupply),
    .ctrl        (ctrl),
    .stat        (stat),
    .faultLatched(faultLatched),
    .pulseActive (pulseActive)
  );

  supv_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .stat        (stat),
    .faultLatched(faultLatched),
    .pulseActive (pulseActive),
    .chipEnInN   (chipEnInN),
    .wdTrip      (wdTrip),
    .wdClear     (wdClear),
    .ctrl        (ctrl),
    .sysRstN     (sysRstN),
    .chipEnOutN  (chipEnOutN),
    .wdFaultN    (wdFaultN),
    .wdStrobeN   (wdStrobeN)
  );

  assign manQualified = stat.qualified;

endmodule

// File: rtl/supv_reset_ctrl_chk.sv
module supv_reset_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic manRstN,
  input logic lowSupply,
  input logic wdTrip,
  input logic wdClear,
  input logic sysRstN,
  input logic chipEnOutN,
  input logic wdFaultN,
  input logic wdStrobeN,
  input logic manQualified
);

  logic [2:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
    end else if (sinceRst != 3'd7) begin
      sinceRst <= sinceRst + 3'd1;
    end
  end

  assign warm = (sinceRst >= 3'd4);

  // R2
  man_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$past(manRstN, 3)) |-> !sysRstN);

  // R4
  sup_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(lowSupply, 3)) |-> !sysRstN);

  // R3
  no_spurious_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(sysRstN) && $past(manRstN, 3) && !$past(lowSupply, 3)) |-> sysRstN);

  // R8
  ce_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sysRstN |-> chipEnOutN);

  // R7
  qual_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    manQualified |-> (wdFaultN && wdStrobeN && !sysRstN));

  // R9
  trip_sets_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdTrip && !wdClear && !manQualified) |=> (!wdFaultN || manQualified));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdClear |=> wdFaultN);

  // R10
  trip_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdTrip && !wdClear && !manQualified) |=> (!wdStrobeN || manQualified));

endmodule

bind supv_reset_ctrl supv_reset_ctrl_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .manRstN     (manRstN),
  .lowSupply   (lowSupply),
  .wdTrip      (wdTrip),
  .wdClear     (wdClear),
  .sysRstN     (sysRstN),
  .chipEnOutN  (chipEnOutN),
  .wdFaultN    (wdFaultN),
  .wdStrobeN   (wdStrobeN),
  .manQualified(manQualified)
);

// File: tb/supv_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module supv_reset_ctrl_tb_top;

  localparam int TMO  = 20;
  localparam int QUAL = 6;
  localparam int PUL  = 4;
  localparam int NVEC = 17;

  // {chipEnInN, wdTrip, wdClear, expChipEnOutN, expWdFaultN, expWdStrobeN}
  localparam logic [5:0] VEC [0:NVEC-1] = '{
    6'b000011, 6'b100111, 6'b010000, 6'b000000, 6'b100100,
    6'b000000, 6'b000001, 6'b001011, 6'b011011, 6'b010000,
    6'b000000, 6'b010000, 6'b000000, 6'b000000, 6'b000000,
    6'b000001, 6'b001011
  };

  logic clk = 1'b0;
  logic rstN, manRstN, lowSupply, chipEnInN, wdTrip, wdClear;
  logic sysRstN, chipEnOutN, wdFaultN, wdStrobeN;
  int   nCmp = 0;
  int   nBad = 0;

  always #2 clk = ~clk;

  supv_reset_ctrl #(
    .TIMEOUT_CYCLES(TMO),
    .QUAL_CYCLES   (QUAL),
    .PULSE_CYCLES  (PUL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .manRstN(manRstN), .lowSupply(lowSupply),
    .chipEnInN(chipEnInN), .wdTrip(wdTrip), .wdClear(wdClear),
    .sysRstN(sysRstN), .chipEnOutN(chipEnOutN), .wdFaultN(wdFaultN),
    .wdStrobeN(wdStrobeN)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #800000;
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rstN = 1'b0; manRstN = 1'b1; lowSupply = 1'b0;
    chipEnInN = 1'b0; wdTrip = 1'b0; wdClear = 1'b0;
    tick(3);
    chk("R1 reset sysRstN", sysRstN, 1'b0);
    chk("R8 reset chipEnOutN", chipEnOutN, 1'b1);
    chk("R1 reset wdFaultN", wdFaultN, 1'b1);
    chk("R1 reset wdStrobeN", wdStrobeN, 1'b1);

    // R1 power-on timeout
    rstN = 1'b1;
    tick(TMO);
    chk("R1 held one edge early", sysRstN, 1'b0);
    tick(1);
    chk("R1 released on time", sysRstN, 1'b1);

    // R8 R9 R10 vector table
    for (int i = 0; i < NVEC; i++) begin
      {chipEnInN, wdTrip, wdClear} = VEC[i][5:3];
      tick(1);
      chk("R8 table chipEnOutN", chipEnOutN, VEC[i][2]);
      chk("R9 table wdFaultN", wdFaultN, VEC[i][1]);
      chk("R10 table wdStrobeN", wdStrobeN, VEC[i][0]);
    end
    wdTrip = 1'b0; wdClear = 1'b0;

    // R2 R3 manual request, short of qualification
    chipEnInN = 1'b0;
    manRstN = 1'b0;
    tick(2);
    chk("R2 not before third edge", sysRstN, 1'b1);
    tick(1);
    chk("R2 asserted on third edge", sysRstN, 1'b0);
    chk("R8 blocked in reset", chipEnOutN, 1'b1);
    tick(1);
    chk("R2 held while low", sysRstN, 1'b0);
    manRstN = 1'b1;
    tick(TMO + 2);
    chk("R3 held one edge early", sysRstN, 1'b0);
    tick(1);
    chk("R3 released on time", sysRstN, 1'b1);
    chk("R8 passthrough after release", chipEnOutN, 1'b0);

    // R4 low supply
    lowSupply = 1'b1;
    tick(2);
    chk("R4 not before third edge", sysRstN, 1'b1);
    tick(1);
    chk("R4 asserted on third edge", sysRstN, 1'b0);
    lowSupply = 1'b0;
    tick(TMO + 2);
    chk("R4 held one edge early", sysRstN, 1'b0);
    tick(1);
    chk("R4 released on time", sysRstN, 1'b1);

    // R5 restart of timeout
    lowSupply = 1'b1;
    tick(3);
    lowSupply = 1'b0;
    tick(10);
    chk("R5 timing in progress", sysRstN, 1'b0);
    lowSupply = 1'b1;
    tick(1);
    lowSupply = 1'b0;
    tick(TMO + 2);
    chk("R5 restarted, still held", sysRstN, 1'b0);
    tick(1);
    chk("R5 released after restart", sysRstN, 1'b1);

    // R6 pulse one edge short of qualifying
    wdTrip = 1'b1;
    tick(1);
    wdTrip = 1'b0;
    chk("R9 fault set", wdFaultN, 1'b0);
    manRstN = 1'b0;
    tick(QUAL - 1);
    manRstN = 1'b1;
    tick(TMO + 3);
    chk("R6 short pulse release", sysRstN, 1'b1);
    chk("R6 short pulse keeps fault", wdFaultN, 1'b0);

    // R6 pulse of exactly the qualifying width
    manRstN = 1'b0;
    tick(QUAL);
    manRstN = 1'b1;
    tick(TMO + 3);
    chk("R6 exact pulse release", sysRstN, 1'b1);
    chk("R6 exact pulse clears fault", wdFaultN, 1'b1);

    // R7 long qualified request with a trip inside
    wdTrip = 1'b1;
    tick(1);
    wdTrip = 1'b0;
    chk("R9 fault set again", wdFaultN, 1'b0);
    manRstN = 1'b0;
    tick(QUAL + 2);
    chk("R7 fault forced high", wdFaultN, 1'b1);
    chk("R7 strobe forced high", wdStrobeN, 1'b1);
    chk("R7 reset held", sysRstN, 1'b0);
    wdTrip = 1'b1;
    tick(1);
    wdTrip = 1'b0;
    chk("R7 trip ignored fault", wdFaultN, 1'b1);
    chk("R7 trip ignored strobe", wdStrobeN, 1'b1);
    manRstN = 1'b1;
    tick(TMO + 3);
    chk("R6 release after qualified", sysRstN, 1'b1);
    chk("R6 fault cleared", wdFaultN, 1'b1);
    chk("R6 strobe cleared", wdStrobeN, 1'b1);

    finish_run();
  end

endmodule